// File: doc/BRIEF.md
# Single-Byte-Correcting Reed-Solomon Stream Decoder

This block decodes one 255-byte Reed-Solomon codeword over 8-bit symbols. The codeword holds 251 payload bytes followed by 4 check bytes. Bytes enter one per accepted beat, with the first byte treated as the highest-degree polynomial coefficient. Four syndromes build up as the bytes arrive, and the 251 payload bytes go into a local store.

After the last byte, the block classifies the word. A word with all-zero syndromes is clean. A word whose syndromes fit a single error has that error located by a step-by-step search and repaired. Any other word is reported as uncorrectable. A word with two corrupted bytes always lands in the uncorrectable class and is never taken for a legal word. The payload is then streamed out, one byte per cycle and in arrival order, with the repair applied. A one-cycle completion pulse carrying exactly one class flag follows the payload.

While a word is being checked and streamed out, the block refuses new input. A synchronous active-high reset returns it to the collecting state from any point. The word is legal when either the clean flag or the fixed flag is raised.

Top module: `rs_sec_decoder`

## Requirements
- R1: A valid codeword is reported clean and its 251 payload bytes come out unchanged. The field is GF(2^8) with polynomial 0x11D, alpha = 0x02. The generator roots are alpha^0..alpha^3, and byte 0 of the stream is the coefficient of x^254.
- R2: Adding any nonzero 8-bit value to any one payload byte (positions 0..250) raises the fixed flag, and the output bytes equal the original payload.
- R3: Adding any nonzero value to one check byte (positions 251..254) raises the fixed flag, and the output payload is untouched.
- R4: A word with exactly two corrupted bytes raises the bad flag and never the clean or fixed flag. Its payload is emitted exactly as it was received.
- R5: In the done cycle exactly one of flag_clean, flag_fixed and flag_bad is high. In every other cycle all three are low.
- R6: Exactly 251 out_valid beats occur per word, in arrival order, and done is high for one cycle, in the cycle after the last beat.
- R7: in_ready is high while a word is being collected. It is low from the cycle after the 255th byte is accepted until done, and high again in the done cycle.
- R8: After reset, in_ready is 1 and out_valid, done and all flags are 0. A reset in the middle of a word discards that word, and the next full word decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Received codeword byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Output payload byte present |
| out_data | output | 8 | Repaired payload byte |
| done | output | 1 | One-cycle end-of-word pulse |
| flag_clean | output | 1 | Word had no error (valid with done) |
| flag_fixed | output | 1 | One byte was repaired (valid with done) |
| flag_bad | output | 1 | Uncorrectable word detected (valid with done) |

## Verification
A corrupted syndrome register shows up after only one word: either a valid codeword is reported as fixed or bad, or a single-error word is repaired at the wrong position, which leaves two bytes of the output wrong. A fault in the location search either moves the repaired byte or changes the flag. Both show up during that word's output stream, up to about 510 cycles after the last input byte. A slip in the store address or the output counter breaks the byte order or the beat count of the very next word. Faults in the state sequence appear as in_ready being high while output is streaming, or as done being missing or misplaced.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
    localparam int SYM_W = 8;
    localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;
    // alpha^-1 for a primitive polynomial with constant term 1
    localparam logic [SYM_W-1:0] ALPHA_INV = FIELD_POLY[SYM_W:1];

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [1:0] {
        VERD_CLEAN = 2'd0,
        VERD_FIX   = 2'd1,
        VERD_BAD   = 2'd2
    } verdict_e;

    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            if (sh[SYM_W-1]) sh = (sh << 1) ^ FIELD_POLY[SYM_W-1:0];
            else             sh = sh << 1;
        end
        return acc;
    endfunction

    function automatic sym_t gf_alpha_pow(input int e);
        sym_t acc;
        acc = sym_t'(1);
        for (int i = 0; i < e; i++) acc = gf_mul(acc, sym_t'(2));
        return acc;
    endfunction
endpackage

// File: rtl/rs_syndrome_acc.sv
`timescale 1ns/1ps
module rs_syndrome_acc import rs_pkg::*; #(
    parameter int NPAR = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear_i,
    input  logic                  push_i,
    input  sym_t                  din_i,
    output sym_t [NPAR-1:0]       synd_o
);
    typedef struct packed {
        sym_t [NPAR-1:0] s;
    } acc_t;

    acc_t st_d, st_q;
    sym_t root [NPAR];

    // one evaluation point per check symbol
    for (genvar g = 0; g < NPAR; g++) begin : g_root
        localparam sym_t ROOT_VAL = gf_alpha_pow(g);
        assign root[g] = ROOT_VAL;
    end

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.s = '0;
        end else if (push_i) begin
            for (int j = 0; j < NPAR; j++) begin
                st_d.s[j] = gf_mul(st_q.s[j], root[j]) ^ din_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign synd_o = st_q.s;

    // R8: with no byte and no clear the accumulated syndromes hold
    a_r8_synd_hold: assert property (@(posedge clk) disable iff (rst)
        (!clear_i && !push_i) |=> $stable(synd_o));
endmodule

// File: rtl/rs_err_locator.sv
`timescale 1ns/1ps
module rs_err_locator import rs_pkg::*; #(
    parameter int NPAR   = 4,
    parameter int CW_LEN = 255,
    localparam int IDX_W = $clog2(CW_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  sym_t [NPAR-1:0]   synd_i,
    output logic              res_valid_o,
    output verdict_e          verdict_o,
    output logic [IDX_W-1:0]  loc_o,
    output sym_t              mag_o
);
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        sym_t             probe;
        logic             valid;
        verdict_e         verdict;
        logic [IDX_W-1:0] loc;
        sym_t             mag;
    } loc_t;

    loc_t st_d, st_q;
    logic all_zero;
    logic single_fit;

    always_comb begin
        all_zero   = (synd_i == '0);
        single_fit = 1'b1;
        for (int j = 0; j < NPAR - 1; j++) begin
            if (synd_i[j] == '0) single_fit = 1'b0;
        end
        for (int j = 1; j < NPAR - 1; j++) begin
            if (gf_mul(synd_i[j], synd_i[j]) != gf_mul(synd_i[j-1], synd_i[j+1]))
                single_fit = 1'b0;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (start_i) begin
            if (all_zero) begin
                st_d.valid   = 1'b1;
                st_d.verdict = VERD_CLEAN;
            end else if (single_fit) begin
                st_d.busy  = 1'b1;
                st_d.idx   = '0;
                // byte 0 sits at degree CW_LEN-1, i.e. alpha^-1
                st_d.probe = gf_mul(synd_i[0], ALPHA_INV);
            end else begin
                st_d.valid   = 1'b1;
                st_d.verdict = VERD_BAD;
            end
        end else if (st_q.busy) begin
            if (st_q.probe == synd_i[1]) begin
                st_d.busy    = 1'b0;
                st_d.valid   = 1'b1;
                st_d.verdict = VERD_FIX;
                st_d.loc     = st_q.idx;
                st_d.mag     = synd_i[0];
            end else if (st_q.idx == IDX_W'(CW_LEN - 1)) begin
                st_d.busy    = 1'b0;
                st_d.valid   = 1'b1;
                st_d.verdict = VERD_BAD;
            end else begin
                st_d.idx   = st_q.idx + 1'b1;
                st_d.probe = gf_mul(st_q.probe, ALPHA_INV);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.verdict <= VERD_CLEAN;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid_o = st_q.valid;
    assign verdict_o   = st_q.verdict;
    assign loc_o       = st_q.loc;
    assign mag_o       = st_q.mag;

    // R1: zero syndromes give a clean verdict on the next cycle
    a_r1_zero_clean: assert property (@(posedge clk) disable iff (rst)
        (start_i && synd_i == '0) |=> (res_valid_o && verdict_o == VERD_CLEAN));
    // R2: a repair carries the first syndrome as its value and a position inside the word
    a_r2_fix_value: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && verdict_o == VERD_FIX) |-> (mag_o == synd_i[0] && mag_o != '0
                                                   && loc_o < IDX_W'(CW_LEN)));
endmodule

// File: rtl/rs_data_store.sv
`timescale 1ns/1ps
module rs_data_store import rs_pkg::*; #(
    parameter int DEPTH = 251,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  sym_t              wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output sym_t              rdata_o
);
    sym_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    always_comb rdata_o = mem[raddr_i];
endmodule

// File: rtl/rs_sec_decoder.sv
`timescale 1ns/1ps
module rs_sec_decoder import rs_pkg::*; #(
    parameter int CW_LEN   = 255,
    parameter int DATA_LEN = 251
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       done,
    output logic       flag_clean,
    output logic       flag_fixed,
    output logic       flag_bad
);
    localparam int NPAR   = CW_LEN - DATA_LEN;
    localparam int IDX_W  = $clog2(CW_LEN);
    localparam int ADDR_W = $clog2(DATA_LEN);

    typedef enum logic [2:0] {
        T_COLLECT, T_CHECK, T_WAIT, T_EMIT, T_FINISH
    } phase_e;

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] cnt;
        logic [IDX_W-1:0] oidx;
        verdict_e         verdict;
        logic [IDX_W-1:0] loc;
        sym_t             mag;
        logic             o_valid;
        sym_t             o_data;
        logic             o_done;
        logic             f_clean;
        logic             f_fixed;
        logic             f_bad;
    } top_t;

    top_t st_d, st_q;

    logic             push;
    logic             we;
    logic             loc_start;
    logic             clr;
    sym_t [NPAR-1:0]  synd;
    logic             res_valid;
    verdict_e         res_verdict;
    logic [IDX_W-1:0] res_loc;
    sym_t             res_mag;
    sym_t             rdata;

    assign push      = in_valid && (st_q.phase == T_COLLECT);
    assign we        = push && (st_q.cnt < IDX_W'(DATA_LEN));
    assign loc_start = (st_q.phase == T_CHECK);
    assign clr       = (st_q.phase == T_FINISH);

    rs_syndrome_acc #(.NPAR(NPAR)) u_synd (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clr),
        .push_i  (push),
        .din_i   (in_data),
        .synd_o  (synd)
    );

    rs_err_locator #(.NPAR(NPAR), .CW_LEN(CW_LEN)) u_loc (
        .clk         (clk),
        .rst         (rst),
        .start_i     (loc_start),
        .synd_i      (synd),
        .res_valid_o (res_valid),
        .verdict_o   (res_verdict),
        .loc_o       (res_loc),
        .mag_o       (res_mag)
    );

    rs_data_store #(.DEPTH(DATA_LEN)) u_store (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (st_q.cnt[ADDR_W-1:0]),
        .wdata_i (in_data),
        .raddr_i (st_q.oidx[ADDR_W-1:0]),
        .rdata_o (rdata)
    );

    always_comb begin
        st_d         = st_q;
        st_d.o_valid = 1'b0;
        st_d.o_done  = 1'b0;
        st_d.f_clean = 1'b0;
        st_d.f_fixed = 1'b0;
        st_d.f_bad   = 1'b0;
        unique case (st_q.phase)
            T_COLLECT: begin
                if (push) begin
                    if (st_q.cnt == IDX_W'(CW_LEN - 1)) begin
                        st_d.cnt   = '0;
                        st_d.phase = T_CHECK;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            T_CHECK: st_d.phase = T_WAIT;
            T_WAIT: begin
                if (res_valid) begin
                    st_d.verdict = res_verdict;
                    st_d.loc     = res_loc;
                    st_d.mag     = res_mag;
                    st_d.oidx    = '0;
                    st_d.phase   = T_EMIT;
                end
            end
            T_EMIT: begin
                st_d.o_valid = 1'b1;
                if (st_q.verdict == VERD_FIX && st_q.loc == st_q.oidx)
                    st_d.o_data = rdata ^ st_q.mag;
                else
                    st_d.o_data = rdata;
                if (st_q.oidx == IDX_W'(DATA_LEN - 1)) st_d.phase = T_FINISH;
                else                                   st_d.oidx  = st_q.oidx + 1'b1;
            end
            T_FINISH: begin
                st_d.o_done  = 1'b1;
                st_d.f_clean = (st_q.verdict == VERD_CLEAN);
                st_d.f_fixed = (st_q.verdict == VERD_FIX);
                st_d.f_bad   = (st_q.verdict == VERD_BAD);
                st_d.phase   = T_COLLECT;
            end
            default: st_d.phase = T_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.phase   <= T_COLLECT;
            st_q.verdict <= VERD_CLEAN;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready   = (st_q.phase == T_COLLECT);
    assign out_valid  = st_q.o_valid;
    assign out_data   = st_q.o_data;
    assign done       = st_q.o_done;
    assign flag_clean = st_q.f_clean;
    assign flag_fixed = st_q.f_fixed;
    assign flag_bad   = st_q.f_bad;

    // R5: exactly one class flag with done
    a_r5_one_flag: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones({flag_clean, flag_fixed, flag_bad}) == 1));
    // R5: flags stay low outside the done cycle
    a_r5_flags_quiet: assert property (@(posedge clk) disable iff (rst)
        !done |-> ({flag_clean, flag_fixed, flag_bad} == 3'b000));
    // R6: done directly follows the last payload beat
    a_r6_done_after_data: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(out_valid) && !out_valid));
    // R7: no input is accepted while payload streams out
    a_r7_ready_low_on_out: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);
endmodule

// File: tb/rs_sec_decoder_bench.sv
`timescale 1ns/1ps
module rs_sec_decoder_bench;
    localparam int N = 255;
    localparam int K = 251;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, out_valid, done, flag_clean, flag_fixed, flag_bad;
    logic [7:0] out_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] dat  [K];
    logic [7:0] cw   [N];
    logic [7:0] rx   [N];
    logic [7:0] got  [K];
    logic [7:0] gpol [5];

    always #2.5 clk = ~clk;

    rs_sec_decoder u_rs_sec_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .done(done), .flag_clean(flag_clean), .flag_fixed(flag_fixed), .flag_bad(flag_bad)
    );

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11D << (i - 8));
        return p[7:0];
    endfunction

    task automatic build_gen();
        logic [7:0] r;
        logic [7:0] nw [5];
        gpol[0] = 8'h01;
        for (int i = 1; i < 5; i++) gpol[i] = 8'h00;
        r = 8'h01;
        for (int j = 0; j < 4; j++) begin
            for (int i = 0; i < 5; i++)
                nw[i] = fmul(gpol[i], r) ^ ((i > 0) ? gpol[i-1] : 8'h00);
            for (int i = 0; i < 5; i++) gpol[i] = nw[i];
            r = fmul(r, 8'h02);
        end
    endtask

    task automatic encode();
        logic [7:0] p0, p1, p2, p3, fb;
        p0 = 0; p1 = 0; p2 = 0; p3 = 0;
        for (int k = 0; k < K; k++) begin
            cw[k] = dat[k];
            fb = dat[k] ^ p3;
            p3 = p2 ^ fmul(fb, gpol[3]);
            p2 = p1 ^ fmul(fb, gpol[2]);
            p1 = p0 ^ fmul(fb, gpol[1]);
            p0 = fmul(fb, gpol[0]);
        end
        cw[251] = p3; cw[252] = p2; cw[253] = p1; cw[254] = p0;
        for (int k = 0; k < N; k++) rx[k] = cw[k];
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_word(input int n_bytes);
        for (int k = 0; k < n_bytes; k++) begin
            @(negedge clk);
            if ($urandom % 8 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = rx[k];
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // kind: 0 clean, 1 fixed, 2 bad
    task automatic run_word(input string req, input int kind);
        int n_out;
        int bad_bytes;
        int guard;
        bit fc, ff, fb;
        send_word(N);
        check(in_ready == 1'b0, "R7", "in_ready while busy", int'(in_ready), 0);
        n_out = 0; bad_bytes = 0; guard = 0;
        fc = 0; ff = 0; fb = 0;
        while (guard < 3000) begin
            if (out_valid) begin
                if (n_out < K) got[n_out] = out_data;
                n_out++;
            end
            if (done) begin
                fc = flag_clean; ff = flag_fixed; fb = flag_bad;
                break;
            end
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, "R6", "done seen", int'(done), 1);
        check(n_out == K, "R6", "beat count", n_out, K);
        for (int k = 0; k < K && k < n_out; k++) begin
            if (got[k] != ((kind == 2) ? rx[k] : dat[k])) bad_bytes++;
        end
        check(bad_bytes == 0, req, "mismatched payload bytes", bad_bytes, 0);
        check({fc, ff, fb} == ((kind == 0) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001),
              req, "flags {clean,fixed,bad}", int'({fc, ff, fb}),
              (kind == 0) ? 4 : (kind == 1) ? 2 : 1);
        check(in_ready == 1'b1, "R7", "in_ready in done cycle", int'(in_ready), 1);
        @(negedge clk);
        check({done, flag_clean, flag_fixed, flag_bad} == 4'b0, "R5",
              "flags after done", int'({done, flag_clean, flag_fixed, flag_bad}), 0);
    endtask

    task automatic fill_random();
        for (int k = 0; k < K; k++) dat[k] = 8'($urandom);
        encode();
    endtask

    initial begin
        void'($urandom(32'h5EED_2025));
        build_gen();
        repeat (3) @(negedge clk);
        check({in_ready, out_valid, done, flag_clean, flag_fixed, flag_bad} == 6'b100000,
              "R8", "outputs in reset",
              int'({in_ready, out_valid, done, flag_clean, flag_fixed, flag_bad}), 32);
        rst = 1'b0;
        @(negedge clk);
        check({in_ready, out_valid, done} == 3'b100, "R8", "outputs after reset",
              int'({in_ready, out_valid, done}), 4);

        // R1: all-zero word, then a random valid word
        for (int k = 0; k < K; k++) dat[k] = 8'h00;
        encode();
        run_word("R1", 0);
        fill_random();
        run_word("R1", 0);

        // R2: payload corners with extreme error values
        fill_random(); rx[0]   = rx[0]   ^ 8'hFF; run_word("R2", 1);
        fill_random(); rx[250] = rx[250] ^ 8'h01; run_word("R2", 1);
        // R3: check-byte corners
        fill_random(); rx[251] = rx[251] ^ 8'h80; run_word("R3", 1);
        fill_random(); rx[254] = rx[254] ^ 8'h5A; run_word("R3", 1);
        // R4: two errors at the extreme ends
        fill_random(); rx[0] ^= 8'h01; rx[254] ^= 8'h01; run_word("R4", 2);

        // R8: reset in the middle of a word, then a clean word
        fill_random();
        send_word(100);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        fill_random();
        run_word("R8", 0);

        // random mix of clean, single and double errors
        for (int t = 0; t < 24; t++) begin
            int kind, p1, p2;
            kind = t % 3;
            fill_random();
            if (kind >= 1) begin
                p1 = $urandom % N;
                rx[p1] ^= 8'(($urandom % 255) + 1);
            end
            if (kind == 2) begin
                p2 = (p1 + 1 + ($urandom % (N - 1))) % N;
                rx[p2] ^= 8'(($urandom % 255) + 1);
            end
            if (kind == 0)      run_word("R1", 0);
            else if (kind == 1) run_word((p1 < K) ? "R2" : "R3", 1);
            else                run_word("R4", 2);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule